// File: doc/BRIEF.md
# SCSI Controller Status Flags and Transfer Counter

This block keeps the sticky status bits of a small SCSI protocol controller: a gross-error bit, a parity-error bit and a terminal-count bit. It also holds the transfer down-counter whose run to zero raises the terminal-count bit. Event strobes come from the FIFO, the DMA path and the phase logic. Command strobes come from the command decoder. An interrupt-register read strobe and the present level of the interrupt output decide when the error bits may be cleared.

Each bit has its own rules for being set and cleared. The error bits clear on a status read only while the interrupt output is high. The terminal-count bit ignores status reads and clears only when a new count is loaded or the chip is reset. A SCSI bus reset leaves every bit and the counter alone. The block also raises a level request to assert ATN when a parity error is caught while the controller acts as initiator in an information-in phase. Interrupt generation, the FIFO and bus sequencing are outside this block.

Top module: `scsi_status_flags`

## Requirements
- R1: The gross-error output goes high on the clock edge after any of three strobes: FIFO top overwritten, DMA direction opposite to the SCSI direction, or an unreconciled synchronous phase change.
- R2: The parity-error output goes high on the edge after a parity-error strobe only while parity checking is enabled. With checking disabled, the strobe leaves it low.
- R3: An interrupt-register read clears the gross-error and parity-error outputs on the next edge only while the interrupt output level is high. A read with the level low leaves them set.
- R4: A hardware reset, or the reset-chip command (command code 0x02 with the command strobe), clears all three status outputs.
- R5: An interrupt-register read never clears the terminal-count output, whatever the interrupt level.
- R6: Every command with bit 7 set (a DMA command, 0x80 being the DMA NOP) loads the counter from the load-value input on the next edge and clears terminal count. Loading zero does not set terminal count. A load in the same cycle as a byte strobe takes the loaded value.
- R7: Each byte strobe decrements the counter by one. Terminal count sets when the counter steps from one to zero. At zero the counter holds and never wraps.
- R8: The non-DMA NOP (command code 0x00) changes neither the counter nor terminal count.
- R9: With parity checking enabled, a parity-error strobe while the initiator input is high and the phase is an information-in phase raises the ATN request on the next edge. The phase input is {msg, c/d, i/o}, and information-in is code 001, 011 or 111. The request stays high until the reset-chip command, a hardware reset, the ATN-release strobe or a SCSI bus reset.
- R10: A SCSI bus reset leaves all three status outputs and the counter unchanged.
- R11: When a set event and a clear event reach the same bit in one cycle, the bit ends up set.
- R12: After hardware reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| fifo_ovwr_i | input | 1 | FIFO top entry overwritten |
| dir_mismatch_i | input | 1 | DMA direction opposite to SCSI transfer direction |
| sync_phase_err_i | input | 1 | Unexpected initiator phase change with unreconciled synchronous offset |
| parity_en_i | input | 1 | Parity checking enabled |
| parity_err_i | input | 1 | Parity error on a command, data, status or message byte |
| initiator_i | input | 1 | Controller is acting as initiator |
| phase_i | input | 3 | Current bus phase {msg, c/d, i/o} |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code; bit 7 marks a DMA command |
| cnt_load_val_i | input | CNT_W | Value loaded by a DMA command |
| byte_xfer_i | input | 1 | One byte transferred |
| int_rd_i | input | 1 | Interrupt-register read strobe |
| int_asserted_i | input | 1 | Interrupt output level |
| scsi_rst_i | input | 1 | SCSI bus reset seen |
| atn_release_i | input | 1 | Phase logic releases the ATN request |
| gross_err_o | output | 1 | Gross-error status |
| parity_err_o | output | 1 | Parity-error status |
| term_cnt_o | output | 1 | Terminal-count status |
| xfer_cnt_o | output | CNT_W | Live transfer count |
| atn_req_o | output | 1 | Request to assert ATN |

## Verification
The bench builds the block with CNT_W set to 4, so the counter spans 0 to 15. This lets a full-scale load drain to zero in fifteen byte strobes. Saturation at zero, the one-to-zero step that sets terminal count, and a zero load can all be driven within a few dozen cycles. The same-cycle load-and-strobe case is also reached in that time. The width is only a parameter of the counter, so the rules on the flags do not depend on it.

// File: rtl/scsi_flag_pkg.sv
package scsi_flag_pkg;

  localparam int unsigned CMD_W    = 8;
  localparam int unsigned PHASE_W  = 3;
  localparam int unsigned N_ERR    = 2;  // gross, parity

  localparam logic [CMD_W-1:0] CMD_NOP       = 8'h00;
  localparam logic [CMD_W-1:0] CMD_RESET_CHIP = 8'h02;
  localparam int unsigned      CMD_DMA_BIT   = 7;

  typedef enum logic [PHASE_W-1:0] {
    PH_DATA_OUT = 3'b000,
    PH_DATA_IN  = 3'b001,
    PH_COMMAND  = 3'b010,
    PH_STATUS   = 3'b011,
    PH_RSVD_OUT = 3'b100,
    PH_RSVD_IN  = 3'b101,
    PH_MSG_OUT  = 3'b110,
    PH_MSG_IN   = 3'b111
  } bus_phase_e;

  typedef enum int unsigned {
    ERR_GROSS  = 0,
    ERR_PARITY = 1
  } err_idx_e;

  function automatic logic is_info_in(input logic [PHASE_W-1:0] ph);
    return (ph == PH_DATA_IN) || (ph == PH_STATUS) || (ph == PH_MSG_IN);
  endfunction

endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;

  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;

endmodule

// File: rtl/flag_cmd_decode.sv
module flag_cmd_decode
  import scsi_flag_pkg::*;
(
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  output logic             cnt_load_o,
  output logic             reset_chip_o,
  output logic             nop_o
);

  always_comb begin
    cnt_load_o   = cmd_valid_i && cmd_code_i[CMD_DMA_BIT];
    reset_chip_o = cmd_valid_i && (cmd_code_i == CMD_RESET_CHIP);
    nop_o        = cmd_valid_i && (cmd_code_i == CMD_NOP);
  end

endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_zero_o
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             dec_ok;

  assign dec_ok     = dec_i && !load_i && (cnt_q != CNT_ZERO);
  assign hit_zero_o = dec_ok && (cnt_q == CNT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= CNT_ZERO;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_ok)  cnt_q <= cnt_q - CNT_ONE;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/scsi_status_flags.sv
module scsi_status_flags
  import scsi_flag_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_ovwr_i,
  input  logic               dir_mismatch_i,
  input  logic               sync_phase_err_i,
  input  logic               parity_en_i,
  input  logic               parity_err_i,
  input  logic               initiator_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               cmd_valid_i,
  input  logic [CMD_W-1:0]   cmd_code_i,
  input  logic [CNT_W-1:0]   cnt_load_val_i,
  input  logic               byte_xfer_i,
  input  logic               int_rd_i,
  input  logic               int_asserted_i,
  input  logic               scsi_rst_i,
  input  logic               atn_release_i,
  output logic               gross_err_o,
  output logic               parity_err_o,
  output logic               term_cnt_o,
  output logic [CNT_W-1:0]   xfer_cnt_o,
  output logic               atn_req_o
);

  logic             cnt_load, reset_chip, nop_seen;
  logic             tc_hit;
  logic             par_hit, atn_set;
  logic             err_clr;
  logic [N_ERR-1:0] err_set, err_q;

  flag_cmd_decode u_dec (
    .cmd_valid_i  (cmd_valid_i),
    .cmd_code_i   (cmd_code_i),
    .cnt_load_o   (cnt_load),
    .reset_chip_o (reset_chip),
    .nop_o        (nop_seen)
  );

  xfer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val_i),
    .dec_i      (byte_xfer_i && !nop_seen),
    .cnt_o      (xfer_cnt_o),
    .hit_zero_o (tc_hit)
  );

  assign par_hit = parity_en_i && parity_err_i;
  assign atn_set = par_hit && initiator_i && is_info_in(phase_i);

  assign err_set[ERR_GROSS]  = fifo_ovwr_i || dir_mismatch_i || sync_phase_err_i;
  assign err_set[ERR_PARITY] = par_hit;
  // status read clears errors only with the interrupt line high
  assign err_clr = (int_rd_i && int_asserted_i) || reset_chip;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set[g]),
      .clr_i  (err_clr),
      .q_o    (err_q[g])
    );
  end

  sticky_flag u_tc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tc_hit),
    .clr_i  (cnt_load || reset_chip),
    .q_o    (term_cnt_o)
  );

  sticky_flag u_atn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (atn_set),
    .clr_i  (reset_chip || atn_release_i || scsi_rst_i),
    .q_o    (atn_req_o)
  );

  assign gross_err_o  = err_q[ERR_GROSS];
  assign parity_err_o = err_q[ERR_PARITY];

endmodule

// File: rtl/scsi_status_flags_chk.sv
module scsi_status_flags_chk
  import scsi_flag_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fifo_ovwr_i,
  input logic               dir_mismatch_i,
  input logic               sync_phase_err_i,
  input logic               parity_en_i,
  input logic               parity_err_i,
  input logic               initiator_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic               cmd_valid_i,
  input logic [CMD_W-1:0]   cmd_code_i,
  input logic [CNT_W-1:0]   cnt_load_val_i,
  input logic               byte_xfer_i,
  input logic               int_rd_i,
  input logic               int_asserted_i,
  input logic               scsi_rst_i,
  input logic               atn_release_i,
  input logic               gross_err_o,
  input logic               parity_err_o,
  input logic               term_cnt_o,
  input logic [CNT_W-1:0]   xfer_cnt_o,
  input logic               atn_req_o
);

  logic c_load, c_rchip, c_gset, c_pset;
  assign c_load  = cmd_valid_i && cmd_code_i[7];
  assign c_rchip = cmd_valid_i && (cmd_code_i == 8'h02);
  assign c_gset  = fifo_ovwr_i || dir_mismatch_i || sync_phase_err_i;
  assign c_pset  = parity_en_i && parity_err_i;

  // R1 and R11: set wins even against a clear
  a_r1_gross_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_gset |=> gross_err_o);

  a_r2_parity_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!parity_en_i && !parity_err_o) |=> !parity_err_o);

  a_r3_keep_without_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gross_err_o && int_rd_i && !int_asserted_i && !c_rchip) |=> gross_err_o);

  a_r3_clear_with_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rd_i && int_asserted_i && !c_pset) |=> !parity_err_o);

  a_r4_rchip_clears_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rchip && !byte_xfer_i) |=> !term_cnt_o);

  a_r5_tc_survives_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_cnt_o && !c_rchip && !c_load) |=> term_cnt_o);

  a_r6_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_load |=> (xfer_cnt_o == $past(cnt_load_val_i)) && !term_cnt_o);

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((xfer_cnt_o == '0) && !c_load) |=> (xfer_cnt_o == '0));

  a_r9_atn_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_pset && initiator_i && phase_i[0] && (phase_i != 3'b101)) |=> atn_req_o);

  a_r9_atn_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atn_release_i && !c_pset) |=> !atn_req_o);

  a_r10_bus_rst_keeps_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scsi_rst_i && term_cnt_o && !c_load && !c_rchip) |=> term_cnt_o);

endmodule

bind scsi_status_flags scsi_status_flags_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/scsi_status_flags_bench.sv
module scsi_status_flags_bench;

  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_ovwr = 0, dir_mm = 0, sync_err = 0;
  logic          par_en = 0, par_err = 0, init = 0;
  logic [2:0]    phase = 3'b000;
  logic          cmd_v = 0;
  logic [7:0]    cmd = 8'h00;
  logic [CW-1:0] ld_val = '0;
  logic          byte_x = 0, int_rd = 0, int_lvl = 0, bus_rst = 0, atn_rel = 0;
  logic          gross, perr, tc, atn;
  logic [CW-1:0] cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scsi_status_flags #(.CNT_W(CW)) u_scsi_status_flags (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_ovwr_i(fifo_ovwr), .dir_mismatch_i(dir_mm), .sync_phase_err_i(sync_err),
    .parity_en_i(par_en), .parity_err_i(par_err), .initiator_i(init), .phase_i(phase),
    .cmd_valid_i(cmd_v), .cmd_code_i(cmd), .cnt_load_val_i(ld_val),
    .byte_xfer_i(byte_x), .int_rd_i(int_rd), .int_asserted_i(int_lvl),
    .scsi_rst_i(bus_rst), .atn_release_i(atn_rel),
    .gross_err_o(gross), .parity_err_o(perr), .term_cnt_o(tc),
    .xfer_cnt_o(cnt), .atn_req_o(atn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one edge, return at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    fifo_ovwr = 0; dir_mm = 0; sync_err = 0; par_err = 0;
    cmd_v = 0; cmd = 8'h00; byte_x = 0; int_rd = 0; bus_rst = 0; atn_rel = 0;
  endtask

  task automatic issue(input logic [7:0] code);
    cmd_v = 1; cmd = code; step(); idle();
  endtask

  task automatic reset_chip();
    issue(8'h02);
  endtask

  task automatic t_reset();
    chk("R12 gross", gross, 0); chk("R12 parity", perr, 0); chk("R12 tc", tc, 0);
    chk("R12 cnt", cnt, 0); chk("R12 atn", atn, 0);
  endtask

  task automatic t_gross();
    fifo_ovwr = 1; step(); idle(); chk("R1 fifo", gross, 1);
    reset_chip(); chk("R4 gross cleared", gross, 0);
    dir_mm = 1; step(); idle(); chk("R1 dir", gross, 1);
    reset_chip();
    sync_err = 1; step(); idle(); chk("R1 sync", gross, 1);
    reset_chip();
  endtask

  task automatic t_parity();
    par_en = 0; par_err = 1; step(); idle(); chk("R2 disabled", perr, 0);
    par_en = 1; par_err = 1; step(); idle(); chk("R2 enabled", perr, 1);
  endtask

  task automatic t_int_read();
    fifo_ovwr = 1; step(); idle();
    int_lvl = 0; int_rd = 1; step(); idle();
    chk("R3 keep gross", gross, 1); chk("R3 keep parity", perr, 1);
    int_lvl = 1; int_rd = 1; step(); idle(); int_lvl = 0;
    chk("R3 clear gross", gross, 0); chk("R3 clear parity", perr, 0);
  endtask

  task automatic t_counter();
    ld_val = 4'd3; issue(8'h91);
    chk("R6 load", cnt, 3); chk("R6 tc low", tc, 0);
    byte_x = 1; step(); step(); idle(); chk("R7 dec", cnt, 1); chk("R7 tc before", tc, 0);
    byte_x = 1; step(); idle(); chk("R7 zero", cnt, 0); chk("R7 tc set", tc, 1);
    byte_x = 1; step(); idle(); chk("R7 no wrap", cnt, 0);
    int_lvl = 1; int_rd = 1; step(); idle(); int_lvl = 0;
    chk("R5 tc kept", tc, 1);
    bus_rst = 1; step(); idle(); chk("R10 tc kept", tc, 1); chk("R10 cnt kept", cnt, 0);
    issue(8'h00); chk("R8 nop tc", tc, 1); chk("R8 nop cnt", cnt, 0);
    ld_val = 4'd0; issue(8'h80); chk("R6 zero load tc", tc, 0); chk("R6 zero cnt", cnt, 0);
    ld_val = 4'd15; issue(8'h80); chk("R6 full load", cnt, 15);
    byte_x = 1; repeat (14) step(); idle(); chk("R7 fourteen", cnt, 1);
    ld_val = 4'd9; cmd_v = 1; cmd = 8'h80; byte_x = 1; step(); idle();
    chk("R6 load beats dec", cnt, 9); chk("R6 no tc", tc, 0);
    ld_val = 4'd1; issue(8'h80);
    byte_x = 1; step(); idle(); chk("R7 tc again", tc, 1);
    ld_val = 4'd5; issue(8'h00); chk("R8 nop no load", cnt, 0);
    reset_chip(); chk("R4 tc cleared", tc, 0);
  endtask

  task automatic t_atn();
    par_en = 1; init = 1; phase = 3'b000; par_err = 1; step(); idle();
    chk("R9 data out no atn", atn, 0);
    phase = 3'b101; par_err = 1; step(); idle(); chk("R9 reserved no atn", atn, 0);
    init = 0; phase = 3'b001; par_err = 1; step(); idle(); chk("R9 target no atn", atn, 0);
    init = 1; phase = 3'b111; par_err = 1; step(); idle(); chk("R9 msg in atn", atn, 1);
    step(); chk("R9 held", atn, 1);
    atn_rel = 1; step(); idle(); chk("R9 release", atn, 0);
    phase = 3'b011; par_err = 1; step(); idle(); chk("R9 status atn", atn, 1);
    bus_rst = 1; step(); idle(); chk("R9 bus reset drops", atn, 0);
    chk("R10 parity kept", perr, 1);
    phase = 3'b001; par_err = 1; step(); idle();
    reset_chip(); chk("R9 rchip drops", atn, 0); chk("R4 parity cleared", perr, 0);
    phase = 3'b001; par_err = 1; step(); idle();
    rst_n = 0; #2; chk("R4 hw reset atn", atn, 0); chk("R4 hw reset parity", perr, 0);
    step(); rst_n = 1; step();
  endtask

  task automatic t_set_wins();
    fifo_ovwr = 1; int_rd = 1; int_lvl = 1; step(); idle(); int_lvl = 0;
    chk("R11 gross vs read", gross, 1);
    par_en = 1; par_err = 1; cmd_v = 1; cmd = 8'h02; step(); idle();
    chk("R11 parity vs rchip", perr, 1);
    init = 1; phase = 3'b001; par_err = 1; atn_rel = 1; step(); idle();
    chk("R11 atn vs release", atn, 1);
    reset_chip();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_gross();
    t_parity();
    t_int_read();
    t_counter();
    t_atn();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule